// File: doc/BRIEF.md
# Per-Channel Gamma Lookup Table

This block holds the gamma correction tables for several display channels in one flat storage array. Each channel owns three tables (red, green and blue), each with one entry per possible component value. Software fills the tables through an address/data register pair. Writing the address register also sets or clears an auto-increment flag, so a whole channel can be streamed in with a single address write followed by a run of data writes.

On the pixel side, a pixel arrives with a channel number. If that channel's gamma enable bit is set, each component is replaced by the entry its value selects in the channel's matching table. Otherwise the pixel passes through unchanged. Both cases see the same one-cycle latency. When no channel has gamma enabled, the storage counts as powered down. Its contents revert to identity ramps, and software reloads the tables after it enables gamma again.

Top module: `gamma_lut_top`

## Requirements
- R1: After reset every table entry holds its own index (identity ramp), `pix_valid_o` is 0 and `pix_o` is 0.
- R2: The storage address of an entry is ch*3*ENT + comp*ENT + idx, where ENT = 2^CW and comp is 0 for red, 1 for green and 2 for blue. The pixel is packed as red in bits [3CW-1:2CW], green in bits [2CW-1:CW] and blue in bits [CW-1:0].
- R3: A pulse on `cfg_addr_we_i` loads `cfg_addr_i` into the address register and latches `cfg_autoinc_i` as the auto-increment flag. A data write in the same cycle goes to the address held before the load.
- R4: With the auto-increment flag set, each data write stores `cfg_data_i` at the current address and then advances the address by one.
- R5: With the auto-increment flag clear, successive data writes all go to the same location, and the last value written stays there.
- R6: An auto-increment from the last entry of the last channel (DEPTH-1) wraps the address to 0.
- R7: A valid pixel on a channel whose `gamma_en_i` bit is 1 leaves with each component replaced by the entry that component selects in that channel's own table.
- R8: A valid pixel on a channel whose `gamma_en_i` bit is 0 leaves unchanged.
- R9: `pix_valid_o` and `pix_o` follow a valid input one clock edge later. While no valid pixel arrives, `pix_valid_o` is 0 and `pix_o` holds its last value.
- R10: While every `gamma_en_i` bit is 0, all tables are forced back to identity ramps and data writes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_addr_we_i | input | 1 | Load the address register |
| cfg_addr_i | input | AW | Start address to load |
| cfg_autoinc_i | input | 1 | Auto-increment flag, latched together with the address |
| cfg_data_we_i | input | 1 | Write one table entry |
| cfg_data_i | input | CW | Entry value |
| gamma_en_i | input | NUM_CH | Per-channel gamma enable |
| pix_valid_i | input | 1 | Input pixel valid |
| pix_ch_i | input | CHW | Channel of the input pixel |
| pix_i | input | 3*CW | Input pixel {R,G,B} |
| pix_valid_o | output | 1 | Output pixel valid |
| pix_o | output | 3*CW | Corrected or bypassed pixel {R,G,B} |

## Verification
The bench builds the block with NUM_CH=2 and CW=4. Each table then has 16 entries and the whole store has 96, so a complete channel load takes 48 writes and the wrap from the last blue entry of channel 1 to the first red entry of channel 0 can be reached directly. The same small size lets one test step through a power-down, where both enables go low, and a reload, then check that a previously written entry has fallen back to identity.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
  typedef enum logic [1:0] {
    COMP_R = 2'd0,
    COMP_G = 2'd1,
    COMP_B = 2'd2
  } comp_e;
  localparam int unsigned COMPS = 3;
endpackage

// File: rtl/gamma_addr_ctrl.sv
module gamma_addr_ctrl #(
  parameter int unsigned DEPTH = 2304,
  parameter int unsigned AW    = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_we_i,
  input  logic [AW-1:0] addr_i,
  input  logic          autoinc_i,
  input  logic          data_we_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] addr_q;
  logic          inc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      inc_q  <= 1'b0;
    end else if (addr_we_i) begin
      addr_q <= addr_i;
      inc_q  <= autoinc_i;
    end else if (data_we_i && inc_q) begin
      addr_q <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;

  assert_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && inc_q && !addr_we_i && addr_q == LAST) |=> (addr_q == '0));

  assert_fixed_addr_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && !inc_q && !addr_we_i) |=> $stable(addr_q));

  assert_advance_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we_i && inc_q && !addr_we_i && addr_q < LAST) |=> (addr_q == $past(addr_q) + 1'b1));
endmodule

// File: rtl/gamma_lut_store.sv
module gamma_lut_store #(
  parameter int unsigned CW    = 8,
  parameter int unsigned DEPTH = 2304,
  parameter int unsigned AW    = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pwr_on_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_r_i,
  input  logic [AW-1:0] raddr_g_i,
  input  logic [AW-1:0] raddr_b_i,
  output logic [CW-1:0] r_o,
  output logic [CW-1:0] g_o,
  output logic [CW-1:0] b_o
);
  localparam int unsigned ENT = 1 << CW;
  localparam logic [CW-1:0] LAST_ID = CW'((DEPTH - 1) % ENT);

  logic [CW-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    localparam logic [CW-1:0] ID_V = CW'(e % ENT);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[e] <= ID_V;
      else if (!pwr_on_i)                           mem_q[e] <= ID_V;  // powered down: contents lost
      else if (we_i && waddr_i == AW'(e))           mem_q[e] <= wdata_i;
    end
  end

  assign r_o = mem_q[raddr_r_i];
  assign g_o = mem_q[raddr_g_i];
  assign b_o = mem_q[raddr_b_i];

  assert_idle_identity_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_on_i |=> (mem_q[DEPTH-1] == LAST_ID));
endmodule

// File: rtl/gamma_pixel_path.sv
module gamma_pixel_path #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CW     = 8,
  parameter int unsigned AW     = 12,
  parameter int unsigned CHW    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] en_i,
  input  logic              valid_i,
  input  logic [CHW-1:0]    ch_i,
  input  logic [3*CW-1:0]   pix_i,
  output logic [AW-1:0]     raddr_r_o,
  output logic [AW-1:0]     raddr_g_o,
  output logic [AW-1:0]     raddr_b_o,
  input  logic [CW-1:0]     r_i,
  input  logic [CW-1:0]     g_i,
  input  logic [CW-1:0]     b_i,
  output logic              valid_o,
  output logic [3*CW-1:0]   pix_o
);
  import gamma_lut_pkg::*;
  localparam int unsigned ENT = 1 << CW;

  logic          ch_ok;
  logic          map_en;
  logic [AW-1:0] base;
  logic          valid_q;
  logic [3*CW-1:0] pix_q;

  if (NUM_CH == (1 << CHW)) begin : g_full
    assign ch_ok = 1'b1;
  end else begin : g_part
    assign ch_ok = (int'(ch_i) < NUM_CH);
  end

  assign map_en = ch_ok && en_i[ch_i];
  assign base   = ch_ok ? AW'(int'(ch_i) * COMPS * ENT) : '0;

  assign raddr_r_o = base + AW'(int'(COMP_R) * ENT) + AW'(pix_i[3*CW-1:2*CW]);
  assign raddr_g_o = base + AW'(int'(COMP_G) * ENT) + AW'(pix_i[2*CW-1:CW]);
  assign raddr_b_o = base + AW'(int'(COMP_B) * ENT) + AW'(pix_i[CW-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      pix_q   <= '0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) pix_q <= map_en ? {r_i, g_i, b_i} : pix_i;
    end
  end

  assign valid_o = valid_q;
  assign pix_o   = pix_q;

  assert_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(pix_o)));

  assert_bypass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ch_ok && !en_i[ch_i]) |=> (pix_o == $past(pix_i)));
endmodule

// File: rtl/gamma_lut_top.sv
module gamma_lut_top #(
  parameter int unsigned NUM_CH = 3,
  parameter int unsigned CW     = 8,
  localparam int unsigned DEPTH = NUM_CH * 3 * (1 << CW),
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned CHW   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_addr_we_i,
  input  logic [AW-1:0]     cfg_addr_i,
  input  logic              cfg_autoinc_i,
  input  logic              cfg_data_we_i,
  input  logic [CW-1:0]     cfg_data_i,
  input  logic [NUM_CH-1:0] gamma_en_i,
  input  logic              pix_valid_i,
  input  logic [CHW-1:0]    pix_ch_i,
  input  logic [3*CW-1:0]   pix_i,
  output logic              pix_valid_o,
  output logic [3*CW-1:0]   pix_o
);
  logic [AW-1:0] waddr;
  logic [AW-1:0] ra_r, ra_g, ra_b;
  logic [CW-1:0] rv_r, rv_g, rv_b;
  logic          pwr_on;
  logic          st_we;

  assign pwr_on = |gamma_en_i;
  assign st_we  = cfg_data_we_i && (int'(waddr) < DEPTH);

  gamma_addr_ctrl #(.DEPTH(DEPTH), .AW(AW)) u_addr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_we_i (cfg_addr_we_i),
    .addr_i    (cfg_addr_i),
    .autoinc_i (cfg_autoinc_i),
    .data_we_i (cfg_data_we_i),
    .addr_o    (waddr)
  );

  gamma_lut_store #(.CW(CW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .pwr_on_i  (pwr_on),
    .we_i      (st_we),
    .waddr_i   (waddr),
    .wdata_i   (cfg_data_i),
    .raddr_r_i (ra_r),
    .raddr_g_i (ra_g),
    .raddr_b_i (ra_b),
    .r_o       (rv_r),
    .g_o       (rv_g),
    .b_o       (rv_b)
  );

  gamma_pixel_path #(.NUM_CH(NUM_CH), .CW(CW), .AW(AW), .CHW(CHW)) u_pix (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (gamma_en_i),
    .valid_i   (pix_valid_i),
    .ch_i      (pix_ch_i),
    .pix_i     (pix_i),
    .raddr_r_o (ra_r),
    .raddr_g_o (ra_g),
    .raddr_b_o (ra_b),
    .r_i       (rv_r),
    .g_i       (rv_g),
    .b_i       (rv_b),
    .valid_o   (pix_valid_o),
    .pix_o     (pix_o)
  );
endmodule

// File: tb/gamma_lut_top_tb_top.sv
`timescale 1ns/1ps
module gamma_lut_top_tb_top;
  localparam int NUM_CH = 2;
  localparam int CW     = 4;
  localparam int ENT    = 1 << CW;
  localparam int DEPTH  = NUM_CH * 3 * ENT;
  localparam int AW     = $clog2(DEPTH);
  localparam int PW     = 3 * CW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_addr_we = 1'b0, cfg_autoinc = 1'b0, cfg_data_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [CW-1:0] cfg_data = '0;
  logic [NUM_CH-1:0] gamma_en = '0;
  logic pix_valid = 1'b0;
  logic [0:0] pix_ch = '0;
  logic [PW-1:0] pix_in = '0;
  logic pix_valid_o;
  logic [PW-1:0] pix_o;

  int n_chk = 0, n_bad = 0;
  logic [CW-1:0] mdl [DEPTH];
  int m_addr = 0;
  bit m_inc = 0;

  always #4 clk = ~clk;

  gamma_lut_top #(.NUM_CH(NUM_CH), .CW(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .cfg_addr_we_i(cfg_addr_we), .cfg_addr_i(cfg_addr), .cfg_autoinc_i(cfg_autoinc),
    .cfg_data_we_i(cfg_data_we), .cfg_data_i(cfg_data),
    .gamma_en_i(gamma_en), .pix_valid_i(pix_valid), .pix_ch_i(pix_ch), .pix_i(pix_in),
    .pix_valid_o(pix_valid_o), .pix_o(pix_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic mdl_identity();
    for (int i = 0; i < DEPTH; i++) mdl[i] = CW'(i % ENT);
  endtask

  task automatic set_addr(input int a, input bit inc);
    @(negedge clk);
    cfg_addr_we = 1'b1; cfg_addr = AW'(a); cfg_autoinc = inc;
    @(negedge clk);
    cfg_addr_we = 1'b0;
    m_addr = a; m_inc = inc;
  endtask

  task automatic wr_data(input int v);
    @(negedge clk);
    cfg_data_we = 1'b1; cfg_data = CW'(v);
    @(negedge clk);
    cfg_data_we = 1'b0;
    if (gamma_en != '0) mdl[m_addr] = CW'(v);
    if (m_inc) m_addr = (m_addr == DEPTH - 1) ? 0 : m_addr + 1;
  endtask

  function automatic logic [PW-1:0] expect_pix(input int ch, input logic [PW-1:0] p);
    int b;
    b = ch * 3 * ENT;
    if (!gamma_en[ch]) return p;
    return {mdl[b + int'(p[3*CW-1:2*CW])], mdl[b + ENT + int'(p[2*CW-1:CW])],
            mdl[b + 2*ENT + int'(p[CW-1:0])]};
  endfunction

  task automatic send_pix(input int ch, input logic [PW-1:0] p, input string tag);
    logic [PW-1:0] e;
    e = expect_pix(ch, p);
    @(negedge clk);
    pix_valid = 1'b1; pix_ch = 1'(ch); pix_in = p;
    @(negedge clk);
    pix_valid = 1'b0;
    chk({tag, " valid"}, 32'(pix_valid_o), 32'd1);
    chk(tag, 32'(pix_o), 32'(e));
  endtask

  task automatic t_reset();
    chk("R1 valid after reset", 32'(pix_valid_o), 32'd0);
    chk("R1 pix after reset", 32'(pix_o), 32'd0);
    gamma_en = 2'b11;
    send_pix(0, 12'hA3C, "R1 identity ch0");
    send_pix(1, 12'h5F0, "R1 identity ch1");
  endtask

  task automatic t_load();
    set_addr(1 * 3 * ENT, 1'b1);
    for (int i = 0; i < ENT; i++) wr_data(15 - i);
    for (int i = 0; i < ENT; i++) wr_data((i + 3) % ENT);
    for (int i = 0; i < ENT; i++) wr_data(i ^ 5);
    send_pix(1, 12'h123, "R2 R4 R7 map ch1 a");
    send_pix(1, 12'hFE0, "R2 R4 R7 map ch1 b");
    send_pix(0, 12'h123, "R7 ch0 untouched");
  endtask

  task automatic t_bypass();
    gamma_en = 2'b01;
    send_pix(1, 12'h123, "R8 bypass ch1");
    send_pix(0, 12'h7E1, "R8 ch0 still mapped");
    gamma_en = 2'b11;
    send_pix(1, 12'h123, "R7 ch1 retained");
  endtask

  task automatic t_fixed();
    set_addr(ENT + 5, 1'b0);
    wr_data(7);
    wr_data(9);
    send_pix(0, 12'h050, "R5 last value kept");
    send_pix(0, 12'h060, "R5 neighbour untouched");
  endtask

  task automatic t_wrap();
    set_addr(DEPTH - 1, 1'b1);
    wr_data(2);
    wr_data(11);
    send_pix(1, 12'h00F, "R6 last entry written");
    send_pix(0, 12'h000, "R6 wrapped to entry 0");
  endtask

  task automatic t_same_cycle();
    // R3: data write in the load cycle uses the old address
    set_addr(2, 1'b0);
    @(negedge clk);
    cfg_addr_we = 1'b1; cfg_addr = AW'(3); cfg_autoinc = 1'b0;
    cfg_data_we = 1'b1; cfg_data = CW'(13);
    @(negedge clk);
    cfg_addr_we = 1'b0; cfg_data_we = 1'b0;
    mdl[2] = CW'(13); m_addr = 3; m_inc = 0;
    wr_data(4);
    send_pix(0, 12'h200, "R3 old address written");
    send_pix(0, 12'h300, "R3 new address written");
  endtask

  task automatic t_powerdown();
    gamma_en = 2'b00;
    repeat (2) @(negedge clk);
    set_addr(7, 1'b0);
    wr_data(1);
    mdl_identity();
    gamma_en = 2'b11;
    send_pix(0, 12'h700, "R10 write dropped while off");
    send_pix(1, 12'h3C4, "R10 identity after power down");
  endtask

  task automatic t_latency();
    logic [PW-1:0] last;
    send_pix(0, 12'h9A5, "R9 one cycle");
    last = pix_o;
    @(negedge clk);
    chk("R9 valid low when idle", 32'(pix_valid_o), 32'd0);
    chk("R9 pix held when idle", 32'(pix_o), 32'(last));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    mdl_identity();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_bypass();
    t_fixed();
    t_wrap();
    t_same_cycle();
    t_powerdown();
    t_latency();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule